// File: doc/BRIEF.md
# Sprite Serializer with One-Line Vertical Delay

This block turns an 8-bit graphics byte into the serial pixel stream of one movable player object on a 160-pixel raster line. A position counter runs on visible pixel clocks only. Each time it wraps through zero, and at extra decode points picked by a 3-bit size code, it starts a scan of the graphics byte. The scan can run in either bit order and can stretch each bit over one, two or four pixels.

The graphics byte is held in two stages. The first stage is loaded by the processor. The second stage copies the first when the companion object's graphics register is written, so the object can be shown one line late. Fine horizontal motion comes from a signed 4-bit value. The value is armed by a strobe, then applied once, starting at the next horizontal blank pulse. A positive value adds clock ticks during blank. A negative value removes visible ticks.

Two state machines control the block. The motion machine has four states:
- `MV_IDLE`: waits for `motion_go`, then goes to `MV_ARMED`.
- `MV_ARMED`: waits for `hblank_start`. It then goes to `MV_INJECT` for a positive value, to `MV_HOLD` for a negative value, or back to `MV_IDLE` for zero.
- `MV_INJECT`: forces one tick per cycle until its count runs out, then returns to `MV_IDLE`.
- `MV_HOLD`: suppresses one visible tick per visible cycle until its count runs out, then returns to `MV_IDLE`.

The scan machine has two states. `SC_IDLE` goes to `SC_RUN` on a tick that carries a copy start. `SC_RUN` goes back to `SC_IDLE` when the last stretched pixel of bit 7 has been sent, unless a new start arrives on that tick.

Top module: `sprite_serializer`

## Requirements
- R1: The position counter advances by one per visible clock (`vis_en`=1) and holds when `vis_en`=0. Its period is 160 ticks, so an unmoved object reappears exactly 160 visible clocks later.
- R2: A copy starts on the tick that moves the counter to a decode point, and its first pixel shows in the following cycle. `pix_out` is 0 whenever `vis_en`=0, whenever no scan is running, and during reset.
- R3: The size code selects the copy start points (counter values):
  - code 0: 0 only
  - code 1: 0 and 16
  - code 2: 0 and 32
  - code 3: 0, 16 and 32
  - code 4: 0 and 64
  - code 6: 0, 32 and 64
- R4: Size code 5 gives one copy with each bit two pixels wide. Size code 7 gives one copy with each bit four pixels wide. All other codes use one pixel per bit.
- R5: With `reflect`=0 the bits are sent D7 first and D0 last. With `reflect`=1 they are sent D0 first and D7 last.
- R6: `gfx_wr` loads `gfx_data` into stage A. `peer_wr` copies stage A into stage B. When both occur in the same cycle, stage B takes the old stage A value. Both stages are zero after reset.
- R7: `vdelay`=0 scans stage A and `vdelay`=1 scans stage B.
- R8: `pos_rst` zeroes the counter at any time, taking priority over a tick, and raises no copy start. The first copy then appears 160 visible clocks later.
- R9: A positive motion value m is added as m extra ticks, one per cycle, after `hblank_start`. The object then first appears after 160−m visible clocks (moved left).
- R10: A negative motion value −n (n up to 8, two's complement in `motion`) withholds the next n visible ticks. The object first appears after 160+n visible clocks (moved right).
- R11: A motion value is applied once per `motion_go`. On later lines the object repeats every 160 visible clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vis_en | input | 1 | High on visible pixel clocks |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blank |
| gfx_wr | input | 1 | Load `gfx_data` into stage A |
| gfx_data | input | 8 | Graphics byte |
| peer_wr | input | 1 | Companion object's graphics write; copies stage A into stage B |
| reflect | input | 1 | Bit order select |
| vdelay | input | 1 | Select stage B (delayed) for the scan |
| size | input | 3 | Copy and stretch code |
| pos_rst | input | 1 | Zero the position counter |
| motion | input | 4 | Signed motion value |
| motion_go | input | 1 | Arm the motion value for the next blank |
| pix_out | output | 1 | Serial pixel |

## Verification
The line-image sweep runs all eight size codes in both bit orders with an asymmetric byte. Each of the 160 pixels of a full line is compared with an image computed from the copy offsets and the stretch factor. This separates wrong copy spacing, wrong stretch and reversed order. The stage tests load different bytes into the two stages, including a cycle where both writes occur together, so a mux-select error or a copy-timing error shows as the wrong byte on the line. The motion runs use values from −8 to +7. They measure the distance to the first and second appearance of a one-pixel object, which separates wrong tick injection, wrong suppression, wrong sign handling and motion applied more than once.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;

    typedef enum logic [1:0] {
        MV_IDLE,
        MV_ARMED,
        MV_INJECT,
        MV_HOLD
    } mv_state_e;

    typedef enum logic {
        SC_IDLE,
        SC_RUN
    } sc_state_e;

endpackage

// File: rtl/ss_position.sv
`timescale 1ns/1ps
module ss_position
    import ss_pkg::*;
#(
    parameter int LINE_PIX = 160,
    parameter int COPY_GAP = 16,
    parameter int MV_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vis_en,
    input  logic            hblank_start,
    input  logic            pos_rst,
    input  logic [MV_W-1:0] motion,
    input  logic            motion_go,
    input  logic [2:0]      size,
    output logic            tick,
    output logic            start
);

    localparam int POS_W = $clog2(LINE_PIX);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_PIX - 1);
    localparam logic [POS_W-1:0] OFF_1    = POS_W'(COPY_GAP);
    localparam logic [POS_W-1:0] OFF_2    = POS_W'(2 * COPY_GAP);
    localparam logic [POS_W-1:0] OFF_4    = POS_W'(4 * COPY_GAP);

    mv_state_e       st, st_nxt;
    logic [MV_W-1:0] mv_val;
    logic [MV_W-1:0] mv_cnt;
    logic [MV_W-1:0] mv_mag;
    logic [POS_W-1:0] pos, pos_nxt;
    logic            hit;

    assign mv_mag = mv_val[MV_W-1] ? (~mv_val + 1'b1) : mv_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= MV_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            MV_IDLE: begin
                if (motion_go) st_nxt = MV_ARMED;
            end
            MV_ARMED: begin
                if (hblank_start) begin
                    if (mv_val == '0)          st_nxt = MV_IDLE;
                    else if (mv_val[MV_W-1])   st_nxt = MV_HOLD;
                    else                       st_nxt = MV_INJECT;
                end
            end
            MV_INJECT: begin
                if (mv_cnt == MV_W'(1)) st_nxt = MV_IDLE;
            end
            MV_HOLD: begin
                if (vis_en && mv_cnt == MV_W'(1)) st_nxt = MV_IDLE;
            end
            default: st_nxt = MV_IDLE;
        endcase
    end

    // motion value and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_val <= '0;
            mv_cnt <= '0;
        end else begin
            if (motion_go && (st == MV_IDLE || st == MV_ARMED))
                mv_val <= motion;
            if (st == MV_ARMED && hblank_start)
                mv_cnt <= mv_mag;
            else if (st == MV_INJECT)
                mv_cnt <= mv_cnt - 1'b1;
            else if (st == MV_HOLD && vis_en)
                mv_cnt <= mv_cnt - 1'b1;
        end
    end

    // outputs: tick gating and copy decode
    always_comb begin
        tick    = (vis_en && st != MV_HOLD) || (st == MV_INJECT);
        pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;
        unique case (size)
            3'd1:    hit = (pos_nxt == OFF_1);
            3'd2:    hit = (pos_nxt == OFF_2);
            3'd3:    hit = (pos_nxt == OFF_1) || (pos_nxt == OFF_2);
            3'd4:    hit = (pos_nxt == OFF_4);
            3'd6:    hit = (pos_nxt == OFF_2) || (pos_nxt == OFF_4);
            default: hit = 1'b0;
        endcase
        start = tick && !pos_rst && ((pos_nxt == '0) || hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pos <= '0;
        else if (pos_rst) pos <= '0;
        else if (tick)   pos <= pos_nxt;
    end

endmodule

// File: rtl/ss_gfx.sv
`timescale 1ns/1ps
module ss_gfx #(
    parameter int GFX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gfx_wr,
    input  logic [GFX_W-1:0] gfx_data,
    input  logic             peer_wr,
    output logic [GFX_W-1:0] stage_a,
    output logic [GFX_W-1:0] stage_b
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            if (gfx_wr)  stage_a <= gfx_data;
            if (peer_wr) stage_b <= stage_a;
        end
    end

endmodule

// File: rtl/ss_scan.sv
`timescale 1ns/1ps
module ss_scan
    import ss_pkg::*;
#(
    parameter int GFX_W = 8,
    parameter int STR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vis_en,
    input  logic             tick,
    input  logic             start,
    input  logic [2:0]       size,
    input  logic             reflect,
    input  logic [GFX_W-1:0] gfx_sel,
    output logic             pix_out
);

    localparam int IDX_W = $clog2(GFX_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GFX_W - 1);

    sc_state_e        st, st_nxt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] bit_pos;
    logic [STR_W-1:0] sub, sub_top;
    logic             sub_last, idx_last;

    always_comb begin
        unique case (size)
            3'd5:    sub_top = STR_W'(1);
            3'd7:    sub_top = STR_W'(3);
            default: sub_top = '0;
        endcase
        sub_last = (sub == sub_top);
        idx_last = (idx == LAST_IDX);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            SC_IDLE: begin
                if (tick && start) st_nxt = SC_RUN;
            end
            SC_RUN: begin
                if (tick && !start && sub_last && idx_last) st_nxt = SC_IDLE;
            end
            default: st_nxt = SC_IDLE;
        endcase
    end

    // bit and stretch counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            sub <= '0;
        end else if (tick) begin
            if (start) begin
                idx <= '0;
                sub <= '0;
            end else if (st == SC_RUN) begin
                if (sub_last) begin
                    sub <= '0;
                    idx <= idx + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    // output
    always_comb begin
        bit_pos = reflect ? idx : (LAST_IDX - idx);
        pix_out = vis_en && (st == SC_RUN) && gfx_sel[bit_pos];
    end

endmodule

// File: rtl/sprite_serializer.sv
`timescale 1ns/1ps
module sprite_serializer #(
    parameter int LINE_PIX = 160,
    parameter int GFX_W    = 8,
    parameter int COPY_GAP = 16,
    parameter int MV_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vis_en,
    input  logic             hblank_start,
    input  logic             gfx_wr,
    input  logic [GFX_W-1:0] gfx_data,
    input  logic             peer_wr,
    input  logic             reflect,
    input  logic             vdelay,
    input  logic [2:0]       size,
    input  logic             pos_rst,
    input  logic [MV_W-1:0]  motion,
    input  logic             motion_go,
    output logic             pix_out
);

    logic             tick_w;
    logic             start_w;
    logic [GFX_W-1:0] stage_a_w;
    logic [GFX_W-1:0] stage_b_w;
    logic [GFX_W-1:0] gfx_sel_w;

    ss_position #(
        .LINE_PIX (LINE_PIX),
        .COPY_GAP (COPY_GAP),
        .MV_W     (MV_W)
    ) i_position (
        .clk          (clk),
        .rst_n        (rst_n),
        .vis_en       (vis_en),
        .hblank_start (hblank_start),
        .pos_rst      (pos_rst),
        .motion       (motion),
        .motion_go    (motion_go),
        .size         (size),
        .tick         (tick_w),
        .start        (start_w)
    );

    ss_gfx #(
        .GFX_W (GFX_W)
    ) i_gfx (
        .clk      (clk),
        .rst_n    (rst_n),
        .gfx_wr   (gfx_wr),
        .gfx_data (gfx_data),
        .peer_wr  (peer_wr),
        .stage_a  (stage_a_w),
        .stage_b  (stage_b_w)
    );

    assign gfx_sel_w = vdelay ? stage_b_w : stage_a_w;

    ss_scan #(
        .GFX_W (GFX_W)
    ) i_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .vis_en  (vis_en),
        .tick    (tick_w),
        .start   (start_w),
        .size    (size),
        .reflect (reflect),
        .gfx_sel (gfx_sel_w),
        .pix_out (pix_out)
    );

endmodule

// File: rtl/ss_checkers.sv
`timescale 1ns/1ps
module ss_chk_position
    import ss_pkg::*;
#(
    parameter int LINE_PIX = 160,
    parameter int POS_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vis_en,
    input logic             pos_rst,
    input logic [POS_W-1:0] pos,
    input mv_state_e        st
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_PIX - 1);

    AST_POS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS); // R1

    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_rst && st == MV_IDLE && vis_en) |=>
        pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1)); // R1

    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_rst && st == MV_IDLE && !vis_en) |=> $stable(pos)); // R1

    AST_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pos_rst |=> pos == '0); // R8

    AST_INJECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_rst && st == MV_INJECT) |=>
        pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1)); // R9

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_rst && st == MV_HOLD) |=> $stable(pos)); // R10

endmodule

module ss_chk_scan
    import ss_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      vis_en,
    input logic      tick,
    input logic      start,
    input sc_state_e st,
    input logic      pix_out
);

    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == SC_RUN) |-> $past(start)); // R2

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && start) |=> st == SC_RUN); // R2

    AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SC_IDLE) |-> !pix_out); // R2

    AST_DARK_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_en |-> !pix_out); // R2

endmodule

module ss_chk_top #(
    parameter int GFX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gfx_wr,
    input logic [GFX_W-1:0] gfx_data,
    input logic             peer_wr,
    input logic [GFX_W-1:0] stage_a,
    input logic [GFX_W-1:0] stage_b
);

    AST_STAGE1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        gfx_wr |=> stage_a == $past(gfx_data)); // R6

    AST_STAGE1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !gfx_wr |=> $stable(stage_a)); // R6

    AST_STAGE2_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        peer_wr |=> stage_b == $past(stage_a)); // R6

    AST_STAGE2_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !peer_wr |=> $stable(stage_b)); // R6

endmodule

bind ss_position ss_chk_position #(
    .LINE_PIX (LINE_PIX),
    .POS_W    (POS_W)
) i_chk_position (
    .clk     (clk),
    .rst_n   (rst_n),
    .vis_en  (vis_en),
    .pos_rst (pos_rst),
    .pos     (pos),
    .st      (st)
);

bind ss_scan ss_chk_scan i_chk_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .vis_en  (vis_en),
    .tick    (tick),
    .start   (start),
    .st      (st),
    .pix_out (pix_out)
);

bind sprite_serializer ss_chk_top #(
    .GFX_W (GFX_W)
) i_chk_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .gfx_wr   (gfx_wr),
    .gfx_data (gfx_data),
    .peer_wr  (peer_wr),
    .stage_a  (stage_a_w),
    .stage_b  (stage_b_w)
);

// File: tb/test_sprite_serializer.sv
`timescale 1ns/1ps
module test_sprite_serializer;

    logic       clk;
    logic       rst_n;
    logic       vis_en;
    logic       hblank_start;
    logic       gfx_wr;
    logic [7:0] gfx_data;
    logic       peer_wr;
    logic       reflect;
    logic       vdelay;
    logic [2:0] size;
    logic       pos_rst;
    logic [3:0] motion;
    logic       motion_go;
    logic       pix_out;

    int checks = 0;
    int errors = 0;

    sprite_serializer i_sprite_serializer (
        .clk          (clk),
        .rst_n        (rst_n),
        .vis_en       (vis_en),
        .hblank_start (hblank_start),
        .gfx_wr       (gfx_wr),
        .gfx_data     (gfx_data),
        .peer_wr      (peer_wr),
        .reflect      (reflect),
        .vdelay       (vdelay),
        .size         (size),
        .pos_rst      (pos_rst),
        .motion       (motion),
        .motion_go    (motion_go),
        .pix_out      (pix_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_bit(string req, int where, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pixel %0d: actual %b expected %b", req, where, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit copy_at(int sz, int c);
        if (c == 0)  return 1'b1;
        if (c == 16) return (sz == 1 || sz == 3);
        if (c == 32) return (sz == 2 || sz == 3 || sz == 6);
        if (c == 64) return (sz == 4 || sz == 6);
        return 1'b0;
    endfunction

    function automatic logic exp_pix(int p, int sz, bit rf, logic [7:0] g);
        int w;
        w = (sz == 5) ? 2 : ((sz == 7) ? 4 : 1);
        for (int k = 0; k < 4; k++) begin
            int c;
            int d;
            c = (k == 0) ? 0 : (8 << k);
            if (copy_at(sz, c)) begin
                d = p - c;
                if (d >= 0 && d < 8 * w)
                    return rf ? g[d / w] : g[7 - d / w];
            end
        end
        return 1'b0;
    endfunction

    // reset the counter, run two lines, compare the second against the image
    task automatic line_check(int sz, bit rf, logic [7:0] g, string req);
        size    = 3'(sz);
        reflect = rf;
        vis_en  = 1'b1;
        pos_rst = 1'b1;
        step();
        pos_rst = 1'b0;
        for (int t = 0; t < 320; t++) begin
            @(negedge clk);
            if (t >= 160) check_bit(req, t - 160, pix_out, exp_pix(t - 160, sz, rf, g));
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_a(logic [7:0] v);
        gfx_data = v;
        gfx_wr   = 1'b1;
        step();
        gfx_wr   = 1'b0;
    endtask

    task automatic write_peer();
        peer_wr = 1'b1;
        step();
        peer_wr = 1'b0;
    endtask

    task automatic motion_run(int m);
        int first;
        int second;
        string req;
        first  = -1;
        second = -1;
        size    = 3'd0;
        reflect = 1'b0;
        vdelay  = 1'b0;
        vis_en  = 1'b1;
        pos_rst = 1'b1;
        step();
        pos_rst = 1'b0;
        vis_en  = 1'b0;
        repeat (3) step();
        motion    = 4'(m);
        motion_go = 1'b1;
        step();
        motion_go    = 1'b0;
        hblank_start = 1'b1;
        step();
        hblank_start = 1'b0;
        repeat (12) step();
        vis_en = 1'b1;
        for (int n = 1; n <= 400; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (pix_out) begin
                if (first < 0)       first = n;
                else if (second < 0) second = n;
            end
        end
        @(posedge clk);
        #1;
        req = (m > 0) ? "R9" : ((m < 0) ? "R10" : "R1");
        check_int(req, first, 160 - m);
        check_int("R11", second - first, 160);
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vis_en = 1'b1; hblank_start = 1'b0;
        gfx_wr = 1'b0; gfx_data = 8'h00; peer_wr = 1'b0;
        reflect = 1'b0; vdelay = 1'b0; size = 3'd0;
        pos_rst = 1'b0; motion = 4'd0; motion_go = 1'b0;
        gfx_data = 8'hFF; gfx_wr = 1'b1;
        repeat (4) step();
        @(negedge clk);
        check_bit("R2", 0, pix_out, 1'b0);   // dark in reset
        @(posedge clk);
        #1;
        gfx_wr = 1'b0;
        rst_n  = 1'b1;

        // stages are zero after reset: line stays dark
        line_check(0, 1'b0, 8'h00, "R6");

        // size and order sweep with an asymmetric byte
        write_a(8'hB2);
        for (int sz = 0; sz < 8; sz++) begin
            for (int rf = 0; rf < 2; rf++) begin
                string req;
                if (rf == 1)                 req = "R5";
                else if (sz == 5 || sz == 7) req = "R4";
                else if (sz == 0)            req = "R2";
                else                         req = "R3";
                line_check(sz, rf[0], 8'hB2, req);
            end
        end

        // counter reset from an arbitrary position
        repeat (37) step();
        line_check(3, 1'b0, 8'hB2, "R8");

        // vertical delay
        write_a(8'h3C);
        vdelay = 1'b1;
        write_peer();
        write_a(8'hE1);
        line_check(0, 1'b0, 8'h3C, "R7");
        vdelay = 1'b0;
        line_check(0, 1'b0, 8'hE1, "R7");
        gfx_data = 8'h0F; gfx_wr = 1'b1; peer_wr = 1'b1;
        step();
        gfx_wr = 1'b0; peer_wr = 1'b0;
        vdelay = 1'b1;
        line_check(0, 1'b1, 8'hE1, "R6");
        vdelay = 1'b0;
        line_check(0, 1'b1, 8'h0F, "R6");

        // motion
        write_a(8'h80);
        motion_run(-8);
        motion_run(-3);
        motion_run(-1);
        motion_run(0);
        motion_run(1);
        motion_run(5);
        motion_run(7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule